// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Processor Core

This block is a compact 32-bit processor that finishes every instruction in one clock cycle. Each cycle it presents the program counter on a word-aligned fetch port and decodes the returned word. It reads two operands from a 32-entry register file, computes through a small ALU, and either writes one register, writes data memory, or redirects the program counter. Instructions use three fixed layouts: register-register, register-immediate and jump. They are drawn from a small integer subset: add, sub, slt, addi, slti, andi, ori, lui, lw, sw, lb, sb, beq, bne, j, jal and jr.

Instruction and data memories sit outside the core. Both are read combinationally in the same cycle, and data writes take effect on the next rising clock edge, under per-byte lane enables. The reset input is asynchronous and active low. It is expected to be released synchronously to the clock. While it is low, the program counter is held at address 0 and no register or memory write takes place.

Top module: `sc_int_core`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0 and `dmem_we` is 0. The first instruction after release is fetched from address 0.
- R2: Register 0 always reads as zero. A write aimed at it, for example `addi r0,r0,5`, leaves it at zero.
- R3: With opcode field [31:26] = 0, funct field [5:0] selects the operation: 32 is add (rd = rs + rt), 34 is sub (rd = rs - rt), and 42 is slt (rd = 1 if rs < rt as signed values, else 0). rs is [25:21], rt is [20:16] and rd is [15:11].
- R4: The immediate is field [15:0] and the destination is rt. addi (opcode 8) and slti (opcode 10) sign-extend the immediate. andi (opcode 12) and ori (opcode 13) zero-extend it.
- R5: lui (opcode 15) writes the immediate to rt bits 31:16 and writes zero to bits 15:0.
- R6: lw (35) and sw (43) use the byte address rs + sign-extended immediate. Negative offsets work. lw writes rt, and sw writes all four byte lanes of the word.
- R7: Byte lanes are little-endian: the byte at byte address A is bits 8*(A mod 4)+7 : 8*(A mod 4) of its word. lb (32) sign-extends that byte into rt. sb (40) writes rt[7:0] to that lane only, with exactly one `dmem_be` bit set.
- R8: beq (4) and bne (5) compare rs with rt. When taken, the next PC is PC + 4 + (sign-extended immediate << 2), which allows backward branches. When not taken, the next PC is PC + 4.
- R9: j (2) jumps to {PC+4 [31:28], field [25:0], 00}. jal (3) does the same and also writes PC + 4 into register 31. jr (opcode 0, funct 8) loads the PC from rs.
- R10: An unrecognised opcode, or an unrecognised funct with opcode 0, writes no register and no memory. It advances the PC by 4.
- R11: Any instruction other than a branch or jump advances the PC by exactly 4 at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Byte address of the instruction being fetched (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Store data, with the byte replicated on all lanes for sb |
| dmem_be | output | 4 | Byte lane enables for a store |
| dmem_we | output | 1 | Store strobe, applied on the next rising edge |
| dmem_rdata | input | 32 | Word read at `dmem_addr[31:2]`, same cycle |

## Verification
An instruction fetched in one cycle shows its store on `dmem_we`, `dmem_addr` and `dmem_wdata` in that same cycle. The memory contents change at the following rising edge. Its register result and next PC become visible only from that edge onward. The bench therefore never samples a result in the cycle that produces it. It runs each program until the fetch port sits on a self-jump, waits two more cycles, and only then reads the stored results from its data array. The PC checks around reset are taken at falling edges: one during reset, one after the first rising edge following release, and one after the second.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  localparam int INSTR_W = 32;
  localparam int IDX_W   = 5;
  localparam int IMM_W   = 16;
  localparam int JTGT_W  = 26;

  typedef enum logic [5:0] {
    OP_RTYPE = 6'd0,
    OP_J     = 6'd2,
    OP_JAL   = 6'd3,
    OP_BEQ   = 6'd4,
    OP_BNE   = 6'd5,
    OP_ADDI  = 6'd8,
    OP_SLTI  = 6'd10,
    OP_ANDI  = 6'd12,
    OP_ORI   = 6'd13,
    OP_LUI   = 6'd15,
    OP_LB    = 6'd32,
    OP_LW    = 6'd35,
    OP_SB    = 6'd40,
    OP_SW    = 6'd43
  } opcode_e;

  typedef enum logic [5:0] {
    FN_JR  = 6'd8,
    FN_ADD = 6'd32,
    FN_SUB = 6'd34,
    FN_SLT = 6'd42
  } funct_e;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_SLT,
    ALU_AND,
    ALU_OR,
    ALU_HIGH
  } alu_op_e;

  typedef enum logic [1:0] {
    WB_ALU,
    WB_MEM,
    WB_LINK
  } wb_sel_e;

  typedef enum logic [1:0] {
    DST_RD,
    DST_RT,
    DST_LINK
  } dst_sel_e;

  typedef struct packed {
    logic     reg_we;
    dst_sel_e dst_sel;
    wb_sel_e  wb_sel;
    alu_op_e  alu_op;
    logic     use_imm;
    logic     zext_imm;
    logic     mem_wr;
    logic     mem_byte;
    logic     br_eq;
    logic     br_ne;
    logic     jump;
    logic     jump_reg;
  } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_core_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [INSTR_W-1:0] instr,
  output ctrl_t              ctrl,
  output logic [IDX_W-1:0]   rs_idx,
  output logic [IDX_W-1:0]   rt_idx,
  output logic [IDX_W-1:0]   rd_idx,
  output logic [DATA_W-1:0]  imm_ext,
  output logic [JTGT_W-1:0]  jtarget
);

  logic [5:0]       opc;
  logic [5:0]       fn;
  logic [IMM_W-1:0] imm;

  assign opc     = instr[31:26];
  assign fn      = instr[5:0];
  assign imm     = instr[IMM_W-1:0];
  assign rs_idx  = instr[25:21];
  assign rt_idx  = instr[20:16];
  assign rd_idx  = instr[15:11];
  assign jtarget = instr[JTGT_W-1:0];

  always_comb begin
    ctrl          = '0;
    ctrl.dst_sel  = DST_RT;
    ctrl.wb_sel   = WB_ALU;
    ctrl.alu_op   = ALU_ADD;
    case (opc)
      OP_RTYPE: begin
        ctrl.dst_sel = DST_RD;
        case (fn)
          FN_ADD: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_ADD; end
          FN_SUB: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SUB; end
          FN_SLT: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SLT; end
          FN_JR:  ctrl.jump_reg = 1'b1;
          default: ;
        endcase
      end
      OP_ADDI: begin ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; end
      OP_SLTI: begin ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_SLT; end
      OP_ANDI: begin
        ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.zext_imm = 1'b1; ctrl.alu_op = ALU_AND;
      end
      OP_ORI: begin
        ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.zext_imm = 1'b1; ctrl.alu_op = ALU_OR;
      end
      OP_LUI: begin ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_HIGH; end
      OP_LW: begin ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.wb_sel = WB_MEM; end
      OP_LB: begin
        ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.wb_sel = WB_MEM; ctrl.mem_byte = 1'b1;
      end
      OP_SW: begin ctrl.use_imm = 1'b1; ctrl.mem_wr = 1'b1; end
      OP_SB: begin ctrl.use_imm = 1'b1; ctrl.mem_wr = 1'b1; ctrl.mem_byte = 1'b1; end
      OP_BEQ: begin ctrl.alu_op = ALU_SUB; ctrl.br_eq = 1'b1; end
      OP_BNE: begin ctrl.alu_op = ALU_SUB; ctrl.br_ne = 1'b1; end
      OP_J:   ctrl.jump = 1'b1;
      OP_JAL: begin
        ctrl.jump = 1'b1; ctrl.reg_we = 1'b1; ctrl.dst_sel = DST_LINK; ctrl.wb_sel = WB_LINK;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (ctrl.zext_imm) imm_ext = {{(DATA_W-IMM_W){1'b0}}, imm};
    else               imm_ext = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 32,
  localparam int AW    = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_b
);

  logic [DATA_W-1:0] entry [NREGS];

  assign entry[0] = '0;

  for (genvar gi = 1; gi < NREGS; gi++) begin : g_entry
    logic              en;
    logic [DATA_W-1:0] q;
    assign en = we && (waddr == AW'(gi));
    always_ff @(posedge clk) begin
      if (en) q <= wdata;
    end
    assign entry[gi] = q;
  end

  assign rdata_a = entry[raddr_a];
  assign rdata_b = entry[raddr_b];

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int HALF  = DATA_W / 2
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y,
  output logic              zero
);

  always_comb begin
    case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_SLT:  y = {{(DATA_W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_HIGH: y = {b[HALF-1:0], {HALF{1'b0}}};
      default:  y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_lsu.sv
module sc_lsu #(
  parameter int DATA_W  = 32,
  localparam int BYTES  = DATA_W / 8,
  localparam int LANE_W = $clog2(BYTES)
) (
  input  logic              byte_op,
  input  logic [LANE_W-1:0] lane,
  input  logic [DATA_W-1:0] store_val,
  input  logic [DATA_W-1:0] load_word,
  output logic [BYTES-1:0]  be,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] load_val
);

  logic [7:0] lane_bytes [BYTES];
  logic [7:0] picked;

  for (genvar gl = 0; gl < BYTES; gl++) begin : g_lane
    assign lane_bytes[gl] = load_word[gl*8 +: 8];
  end

  assign picked = lane_bytes[lane];

  always_comb begin
    if (byte_op) begin
      be       = BYTES'(1) << lane;
      wdata    = {BYTES{store_val[7:0]}};
      load_val = {{(DATA_W-8){picked[7]}}, picked};
    end else begin
      be       = '1;
      wdata    = store_val;
      load_val = load_word;
    end
  end

endmodule

// File: rtl/sc_int_core.sv
module sc_int_core
  import sc_core_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREGS  = 32,
  localparam int BYTES  = DATA_W / 8,
  localparam int LANE_W = $clog2(BYTES),
  localparam int AW     = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [DATA_W-1:0] imem_addr,
  input  logic [INSTR_W-1:0] imem_rdata,
  output logic [DATA_W-1:0] dmem_addr,
  output logic [DATA_W-1:0] dmem_wdata,
  output logic [BYTES-1:0]  dmem_be,
  output logic              dmem_we,
  input  logic [DATA_W-1:0] dmem_rdata
);

  ctrl_t             ctrl;
  logic [AW-1:0]     rs_idx, rt_idx, rd_idx, wr_idx;
  logic [DATA_W-1:0] imm_ext;
  logic [JTGT_W-1:0] jtarget;
  logic [DATA_W-1:0] rs_val, rt_val, alu_b, alu_y, load_val, wb_data;
  logic              alu_zero, wr_en, br_taken;
  logic [DATA_W-1:0] pc_q, pc_d, pc_plus4, br_target, j_target;
  logic              pc_en;

  sc_decode #(.DATA_W(DATA_W)) u_dec (
    .instr   (imem_rdata),
    .ctrl    (ctrl),
    .rs_idx  (rs_idx),
    .rt_idx  (rt_idx),
    .rd_idx  (rd_idx),
    .imm_ext (imm_ext),
    .jtarget (jtarget)
  );

  always_comb begin
    case (ctrl.dst_sel)
      DST_RD:   wr_idx = rd_idx;
      DST_LINK: wr_idx = AW'(NREGS - 1);
      default:  wr_idx = rt_idx;
    endcase
  end

  assign wr_en = ctrl.reg_we & rst_n;

  sc_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
    .clk     (clk),
    .we      (wr_en),
    .waddr   (wr_idx),
    .wdata   (wb_data),
    .raddr_a (rs_idx),
    .rdata_a (rs_val),
    .raddr_b (rt_idx),
    .rdata_b (rt_val)
  );

  assign alu_b = ctrl.use_imm ? imm_ext : rt_val;

  sc_alu #(.DATA_W(DATA_W)) u_alu (
    .op   (ctrl.alu_op),
    .a    (rs_val),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  sc_lsu #(.DATA_W(DATA_W)) u_lsu (
    .byte_op   (ctrl.mem_byte),
    .lane      (alu_y[LANE_W-1:0]),
    .store_val (rt_val),
    .load_word (dmem_rdata),
    .be        (dmem_be),
    .wdata     (dmem_wdata),
    .load_val  (load_val)
  );

  assign dmem_addr = alu_y;
  assign dmem_we   = ctrl.mem_wr & rst_n;

  always_comb begin
    case (ctrl.wb_sel)
      WB_MEM:  wb_data = load_val;
      WB_LINK: wb_data = pc_plus4;
      default: wb_data = alu_y;
    endcase
  end

  // next-state logic for the program counter
  assign pc_plus4  = pc_q + DATA_W'(4);
  assign br_target = pc_plus4 + {imm_ext[DATA_W-3:0], 2'b00};
  assign j_target  = {pc_plus4[DATA_W-1:JTGT_W+2], jtarget, 2'b00};
  assign br_taken  = (ctrl.br_eq & alu_zero) | (ctrl.br_ne & ~alu_zero);
  assign pc_en     = 1'b1;

  always_comb begin
    if (ctrl.jump_reg)  pc_d = rs_val;
    else if (ctrl.jump) pc_d = j_target;
    else if (br_taken)  pc_d = br_target;
    else                pc_d = pc_plus4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assign imem_addr = pc_q;

  // R1: first fetch after reset release comes from address zero
  a_r1_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> imem_addr == '0);

  // R2: register zero presents zero to the datapath
  a_r2_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_rdata[25:21] == 5'd0) |-> rs_val == '0);

  // R3: a subtraction result added back to its subtrahend gives the minuend
  a_r3_sub_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_rdata[31:26] == 6'd0 && imem_rdata[5:0] == 6'd34) |-> (wb_data + rt_val) == rs_val);

  // R5: the upper-immediate load leaves the low half clear
  a_r5_lui_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_rdata[31:26] == 6'd15) |-> (wr_en && wb_data[15:0] == 16'h0));

  // R7: a byte store enables exactly the lane its address selects
  a_r7_byte_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (dmem_we && imem_rdata[31:26] == 6'd40) |->
      ($countones(dmem_be) == 1 && dmem_be[dmem_addr[LANE_W-1:0]]));

  // R9: jump-and-link writes the following address to the last register
  a_r9_link_value: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_rdata[31:26] == 6'd3) |-> (wr_en && wr_idx == AW'(NREGS - 1) && wb_data == imem_addr + DATA_W'(4)));

  // R10: only the two store opcodes may strobe data memory
  a_r10_store_only: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> (imem_rdata[31:26] == 6'd43 || imem_rdata[31:26] == 6'd40));

  // R11: non-control instructions step the PC by one word
  a_r11_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    !(imem_rdata[31:26] inside {6'd2, 6'd3, 6'd4, 6'd5} ||
      (imem_rdata[31:26] == 6'd0 && imem_rdata[5:0] == 6'd8))
    |=> imem_addr == $past(imem_addr) + DATA_W'(4));

endmodule

// File: tb/sim_sc_int_core.sv
module sim_sc_int_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic [3:0]  dmem_be;
  logic        dmem_we;

  logic [31:0] imem [0:2047];
  logic [31:0] dmem [0:1023];

  int n_checks = 0;
  int n_fail   = 0;
  int pc_idx   = 0;
  int cyc      = 0;

  localparam logic [31:0] FILL = 32'hCCCC_CCCC;

  always #10 clk = ~clk;

  sc_int_core u0 (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_be(dmem_be), .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[12:2]];
  assign dmem_rdata = dmem[dmem_addr[11:2]];

  always @(posedge clk) begin
    if (dmem_we) begin
      for (int b = 0; b < 4; b++)
        if (dmem_be[b]) dmem[dmem_addr[11:2]][b*8 +: 8] <= dmem_wdata[b*8 +: 8];
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: act cycles=%0d exp below 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%08h exp=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int fn, int rd, int rs, int rt);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rt, int rs, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int op, int tgt);
    return {6'(op), 26'(tgt)};
  endfunction
  function automatic logic [31:0] sx16(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic emit(logic [31:0] w);
    imem[pc_idx] = w;
    pc_idx++;
  endtask
  task automatic put_const(int r, logic [31:0] v);
    emit(enc_i(15, r, 0, int'(v[31:16])));
    emit(enc_i(13, r, r, int'(v[15:0])));
  endtask
  task automatic store(int r, int slot);
    emit(enc_i(43, r, 0, slot * 4));
  endtask

  task automatic clear_all();
    for (int i = 0; i < 2048; i++) imem[i] = 32'h0;
    for (int i = 0; i < 1024; i++) dmem[i] = FILL;
    pc_idx = 0;
  endtask

  // runs the loaded program until the fetch port sits on its self-jump
  task automatic run_to(int halt_idx, bit check_start);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    if (check_start) begin
      check("R1 pc in reset", imem_addr, 32'h0);
      check("R1 no store in reset", {31'h0, dmem_we}, 32'h0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    if (check_start) check("R11 pc after first edge", imem_addr, 32'h4);
    @(negedge clk);
    if (check_start) check("R11 pc after second edge", imem_addr, 32'h8);
    for (int k = 0; k < 5000; k++) begin
      if (imem_addr == 32'(halt_idx * 4)) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    check("R11 reached halt", imem_addr, 32'(halt_idx * 4));
  endtask

  logic [31:0] vals [8];

  initial begin
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
    vals[2] = 32'hFFFF_FFFF; vals[3] = 32'h7FFF_FFFF;
    vals[4] = 32'h8000_0000; vals[5] = 32'h0000_8000;
    vals[6] = 32'h1234_5678; vals[7] = 32'hFEDC_8001;

    // phase 1: arithmetic sweep over all operand pairs
    clear_all();
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        int base;
        base = (i * 8 + j) * 7;
        put_const(8, vals[i]);
        put_const(9, vals[j]);
        emit(enc_r(32, 10, 8, 9)); store(10, base);
        emit(enc_r(34, 11, 8, 9)); store(11, base + 1);
        emit(enc_r(42, 12, 8, 9)); store(12, base + 2);
        emit(enc_i(8, 13, 8, int'(vals[j][15:0])));  store(13, base + 3);
        emit(enc_i(10, 14, 8, int'(vals[j][15:0]))); store(14, base + 4);
        emit(enc_i(12, 15, 8, int'(vals[j][15:0]))); store(15, base + 5);
        emit(enc_i(13, 16, 8, int'(vals[j][15:0]))); store(16, base + 6);
      end
    end
    for (int i = 0; i < 8; i++) begin
      emit(enc_i(8, 17, 0, -1));
      emit(enc_i(15, 17, 0, int'(vals[i][31:16])));
      store(17, 448 + i);
    end
    emit(enc_i(8, 0, 0, 5));
    emit(enc_r(32, 18, 0, 0));
    store(18, 460);
    store(0, 461);
    emit(enc_j(2, pc_idx));
    run_to(pc_idx - 1, 1'b1);

    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [31:0] a, b, si, zi;
        int base;
        a = vals[i]; b = vals[j];
        si = sx16(b[15:0]); zi = {16'h0, b[15:0]};
        base = (i * 8 + j) * 7;
        check("R3 add", dmem[base], a + b);
        check("R3 sub", dmem[base + 1], a - b);
        check("R3 slt", dmem[base + 2], ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
        check("R4 addi", dmem[base + 3], a + si);
        check("R4 slti", dmem[base + 4], ($signed(a) < $signed(si)) ? 32'd1 : 32'd0);
        check("R4 andi", dmem[base + 5], a & zi);
        check("R4 ori", dmem[base + 6], a | zi);
      end
    end
    for (int i = 0; i < 8; i++)
      check("R5 lui", dmem[448 + i], {vals[i][31:16], 16'h0});
    check("R2 r0 after write", dmem[460], 32'h0);
    check("R2 store of r0", dmem[461], 32'h0);

    // phase 2: word and byte memory access
    clear_all();
    dmem[600] = 32'h80F1_7F02;
    dmem[602] = 32'h1122_3344;
    emit(enc_i(32, 1, 0, 2400)); store(1, 0);
    emit(enc_i(32, 2, 0, 2401)); store(2, 1);
    emit(enc_i(32, 3, 0, 2402)); store(3, 2);
    emit(enc_i(32, 4, 0, 2403)); store(4, 3);
    emit(enc_i(8, 5, 0, 2408));
    emit(enc_i(35, 6, 5, -8));   store(6, 4);
    emit(enc_i(43, 6, 5, -4));
    emit(enc_i(40, 4, 5, 1));
    emit(enc_i(40, 2, 5, 3));
    emit(enc_i(32, 7, 5, 3));    store(7, 5);
    emit(enc_j(2, pc_idx));
    run_to(pc_idx - 1, 1'b0);
    check("R7 lb lane0", dmem[0], 32'h0000_0002);
    check("R7 lb lane1", dmem[1], 32'h0000_007F);
    check("R7 lb lane2 negative", dmem[2], 32'hFFFF_FFF1);
    check("R7 lb lane3 negative", dmem[3], 32'hFFFF_FF80);
    check("R6 lw negative offset", dmem[4], 32'h80F1_7F02);
    check("R6 sw negative offset", dmem[601], 32'h80F1_7F02);
    check("R7 sb lanes 1 and 3 only", dmem[602], 32'h7F22_8044);
    check("R7 lb after sb", dmem[5], 32'h0000_007F);
    check("R7 neighbour word kept", dmem[600], 32'h80F1_7F02);

    // phase 3: branches, jumps, link and unrecognised encodings
    clear_all();
    emit(enc_i(8, 1, 0, 3));      // 0
    emit(enc_i(8, 2, 0, 3));      // 1
    emit(enc_i(8, 3, 0, 1));      // 2
    emit(enc_i(8, 4, 0, 2));      // 3
    emit(enc_i(8, 5, 0, 7));      // 4
    emit(enc_i(4, 2, 1, 1));      // 5 beq taken -> 7
    store(4, 0);                  // 6 skipped
    store(3, 1);                  // 7
    emit(enc_i(4, 5, 1, 1));      // 8 beq not taken
    store(3, 2);                  // 9
    emit(enc_i(5, 5, 1, 1));      // 10 bne taken -> 12
    store(4, 3);                  // 11 skipped
    emit(enc_i(5, 2, 1, 1));      // 12 bne not taken
    store(3, 4);                  // 13
    emit(enc_i(8, 6, 0, 0));      // 14
    emit(enc_i(8, 7, 0, 5));      // 15
    emit(enc_i(8, 6, 6, 1));      // 16
    emit(enc_i(5, 7, 6, -2));     // 17 back to 16
    store(6, 5);                  // 18
    emit(enc_j(2, 21));           // 19
    store(4, 6);                  // 20 skipped
    store(3, 7);                  // 21
    emit(enc_j(3, 40));           // 22 jal
    store(31, 8);                 // 23
    emit(enc_i(63, 3, 0, 77));    // 24 unknown opcode
    emit(enc_i(41, 4, 0, 36));    // 25 unknown store-like opcode
    emit(enc_r(63, 3, 1, 2));     // 26 unknown funct
    store(3, 10);                 // 27
    emit(enc_j(2, 28));           // 28 halt
    pc_idx = 40;
    store(3, 11);                 // 40
    emit(enc_r(8, 0, 31, 0));     // 41 jr r31
    run_to(28, 1'b0);
    check("R8 beq taken skips", dmem[0], FILL);
    check("R8 beq taken target", dmem[1], 32'd1);
    check("R8 beq not taken", dmem[2], 32'd1);
    check("R8 bne taken skips", dmem[3], FILL);
    check("R8 bne not taken", dmem[4], 32'd1);
    check("R8 backward loop count", dmem[5], 32'd5);
    check("R9 j skips", dmem[6], FILL);
    check("R9 j target", dmem[7], 32'd1);
    check("R9 jal link value", dmem[8], 32'd92);
    check("R9 callee ran", dmem[11], 32'd1);
    check("R10 unknown ops no reg write", dmem[10], 32'd1);
    check("R10 unknown op no store", dmem[9], FILL);

    summary();
    $finish;
  end

endmodule